// File: doc/BRIEF.md
# Match-Compare System Timer

A free-running 32-bit up-counter with four compare channels, reached through a simple register bus. The counter advances once for each cycle in which the tick-enable input is high, wraps from all-ones to zero, and can be read or overwritten at any time. Each channel has a compare register. When the counter moves onto a channel's compare value, that channel's sticky status bit sets. Status bits stay set until software clears them by writing a one to the bit.

Each channel drives its own level interrupt line, which an enable bit gates. The highest channel can also drive a watchdog. After software arms the watchdog, it cannot disarm it short of a reset. While the watchdog is armed, a compare event on that channel produces a one-cycle reset request.

Comparison is exact equality. A target that the counter has already passed fires only after the counter wraps all the way round. Software should therefore program targets a comfortable margin ahead of the live count; sixteen ticks is the recommended minimum.

Top module: `match_timer`

## Requirements
- R1: After reset, every register reads 0, all interrupt lines are low and the reset request is low.
- R2: The counter (word offset 0x10) increases by one on each clock with tick_en high and holds otherwise; 0xFFFFFFFF steps to 0x00000000.
- R3: A bus write to the counter loads the written value directly; a write in the same cycle as a tick leaves exactly the written value.
- R4: The compare registers of channels 0..3 sit at offsets 0x00, 0x04, 0x08 and 0x0C; each reads back the last value written to it.
- R5: Status bit N (offset 0x14, bit N) becomes 1 in the same cycle that a tick brings the counter equal to compare register N. Loading the counter with a value equal to a compare value does not set it.
- R6: Writing status with bit N = 1 clears bit N, and writing bit N = 0 leaves it unchanged. If a compare event and a clear on the same bit fall in one cycle, the bit ends up set.
- R7: irq[N] is high exactly while status bit N and enable bit N (offset 0x1C, bit N) are both 1.
- R8: The watchdog arm flag is bit 0 at offset 0x18 and is the only bit stored there. Writing it as 1 sets it. No later write clears it; only reset does.
- R9: While the arm flag is set, a compare event on channel 3 drives wdog_rst_req high for exactly one cycle, the same cycle in which status bit 3 sets. With the flag clear, the event still sets status bit 3 but requests no reset.
- R10: Reads of unmapped addresses return 0 and writes to them change nothing. Unmapped means offset 0x20 and above, or an address whose two low bits are not both zero.
- R11: A compare target that is already behind the counter does not fire until the counter wraps through zero and reaches it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance strobe, one step per high cycle |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading a mapped register |
| irq | output | 4 | Per-channel level interrupt |
| wdog_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, four channels, watchdog on channel 3 and a 6-bit byte address. The 6-bit address leaves a block of unmapped offsets above the eight registers. Full-width counting would take billions of ticks to wrap. Because the counter is writable, the bench can preload it a few ticks short of all-ones, which brings both the wrap and the late-firing case for targets already passed within a few dozen cycles. Randomly placed targets at random distances confirm that each compare event lands on the exact tick.

// File: rtl/match_timer_pkg.sv
`timescale 1ns/1ps
package match_timer_pkg;

  // Word slots of the register block; the order is the bus map.
  localparam int SLOT_BITS = 3;
  localparam int CMP_SLOTS = 4;

  typedef enum logic [SLOT_BITS-1:0] {
    SLOT_CMP0  = 3'd0,
    SLOT_CMP1  = 3'd1,
    SLOT_CMP2  = 3'd2,
    SLOT_CMP3  = 3'd3,
    SLOT_COUNT = 3'd4,
    SLOT_STAT  = 3'd5,
    SLOT_WDOG  = 3'd6,
    SLOT_IEN   = 3'd7
  } slot_e;

  typedef struct packed {
    logic  wr;
    logic  rd;
    logic  mapped;
    slot_e slot;
  } bus_dec_t;

endpackage

// File: rtl/mt_decode.sv
`timescale 1ns/1ps
module mt_decode
  import match_timer_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output bus_dec_t          dec
);
  localparam int SLOT_LSB = 2;
  localparam int SLOT_MSB = SLOT_LSB + SLOT_BITS - 1;

  logic aligned;
  logic in_window;

  assign aligned = (addr[SLOT_LSB-1:0] == '0);

  generate
    if (ADDR_W > SLOT_MSB + 1) begin : g_wide
      assign in_window = (addr[ADDR_W-1:SLOT_MSB+1] == '0);
    end else begin : g_exact
      assign in_window = 1'b1;
    end
  endgenerate

  assign dec.wr     = sel & wr;
  assign dec.rd     = sel & ~wr;
  assign dec.mapped = aligned & in_window;
  assign dec.slot   = slot_e'(addr[SLOT_MSB:SLOT_LSB]);

endmodule

// File: rtl/mt_counter.sv
`timescale 1ns/1ps
module mt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_q,
  output logic         step
);
  function automatic logic [W-1:0] advance(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  // A bus load overrides the tick in the same cycle.
  assign step = tick_en & ~ld_en;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (ld_en) cnt_q <= ld_val;
    else if (step)  cnt_q <= advance(cnt_q);
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt_q == $past(cnt_q) + W'(1));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld_en) |=> $stable(cnt_q));
  // R3
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> cnt_q == $past(ld_val));

endmodule

// File: rtl/mt_channel.sv
`timescale 1ns/1ps
module mt_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_q,
  input  logic         step,
  input  logic         match_wr,
  input  logic [W-1:0] wdata,
  input  logic         stat_clr,
  output logic [W-1:0] match_q,
  output logic         hit,
  output logic         stat_q
);
  // True when the coming tick lands the counter exactly on the target.
  function automatic logic lands_on(input logic [W-1:0] now,
                                    input logic [W-1:0] target,
                                    input logic         adv);
    return adv && ((now + W'(1)) == target);
  endfunction

  assign hit = lands_on(cnt_q, match_q, step);

  always_ff @(posedge clk) begin
    if (!rst_n)        match_q <= '0;
    else if (match_wr) match_q <= wdata;
  end

  // Set outranks clear.
  always_ff @(posedge clk) begin
    if (!rst_n)        stat_q <= 1'b0;
    else if (hit)      stat_q <= 1'b1;
    else if (stat_clr) stat_q <= 1'b0;
  end

  // R4
  match_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_wr |=> match_q == $past(wdata));
  // R5
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> stat_q && cnt_q == match_q);
  // R6
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !hit) |=> !stat_q);
  // R6
  stat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !stat_clr) |=> stat_q);

endmodule

// File: rtl/mt_wdog.sv
`timescale 1ns/1ps
module mt_wdog (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_wr,
  input  logic arm_bit,
  input  logic trig,
  output logic en_q,
  output logic req_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                  en_q <= 1'b0;
    else if (arm_wr && arm_bit)  en_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= en_q & trig;
  end

  // R8
  wdog_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
  // R9
  req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(en_q) && $past(trig));
  // R9
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

endmodule

// File: rtl/match_timer.sv
`timescale 1ns/1ps
module match_timer
  import match_timer_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 6,
  parameter int WDOG_CH = NUM_CH - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq,
  output logic              wdog_rst_req
);
  bus_dec_t dec;
  logic     wr_ok;
  logic     wr_count, wr_stat, wr_wdog, wr_ien;

  logic [CNT_W-1:0]  cnt_q;
  logic              step;
  logic [NUM_CH-1:0] hit_vec;
  logic [NUM_CH-1:0] stat_vec;
  logic [NUM_CH-1:0] stat_clr;
  logic [NUM_CH-1:0] ien_q;
  logic [CNT_W-1:0]  match_arr [NUM_CH];
  logic              wdog_en;

  mt_decode #(.ADDR_W(ADDR_W)) u_decode (
    .sel  (bus_sel),
    .wr   (bus_wr),
    .addr (bus_addr),
    .dec  (dec)
  );

  assign wr_ok    = dec.wr & dec.mapped;
  assign wr_count = wr_ok & (dec.slot == SLOT_COUNT);
  assign wr_stat  = wr_ok & (dec.slot == SLOT_STAT);
  assign wr_wdog  = wr_ok & (dec.slot == SLOT_WDOG);
  assign wr_ien   = wr_ok & (dec.slot == SLOT_IEN);
  assign stat_clr = wr_stat ? bus_wdata[NUM_CH-1:0] : '0;

  mt_counter #(.W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .ld_en   (wr_count),
    .ld_val  (bus_wdata),
    .cnt_q   (cnt_q),
    .step    (step)
  );

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam logic [SLOT_BITS-1:0] MY_SLOT = SLOT_BITS'(ch);
      logic match_wr;
      assign match_wr = wr_ok & (dec.slot == slot_e'(MY_SLOT));

      mt_channel #(.W(CNT_W)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_q    (cnt_q),
        .step     (step),
        .match_wr (match_wr),
        .wdata    (bus_wdata),
        .stat_clr (stat_clr[ch]),
        .match_q  (match_arr[ch]),
        .hit      (hit_vec[ch]),
        .stat_q   (stat_vec[ch])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      ien_q <= '0;
    else if (wr_ien) ien_q <= bus_wdata[NUM_CH-1:0];
  end

  assign irq = stat_vec & ien_q;

  mt_wdog u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_wr  (wr_wdog),
    .arm_bit (bus_wdata[0]),
    .trig    (hit_vec[WDOG_CH]),
    .en_q    (wdog_en),
    .req_q   (wdog_rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (dec.rd && dec.mapped) begin
      case (dec.slot)
        SLOT_COUNT: bus_rdata = cnt_q;
        SLOT_STAT:  bus_rdata = CNT_W'(stat_vec);
        SLOT_WDOG:  bus_rdata = CNT_W'(wdog_en);
        SLOT_IEN:   bus_rdata = CNT_W'(ien_q);
        default: begin
          for (int c = 0; c < NUM_CH; c++)
            if (dec.slot == slot_e'(c[SLOT_BITS-1:0])) bus_rdata = match_arr[c];
        end
      endcase
    end
  end

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !dec.mapped) |-> bus_rdata == '0);
  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !dec.mapped && !tick_en) |=>
      $stable(cnt_q) && $stable(ien_q) && $stable(wdog_en));
  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[0]) |-> $past(hit_vec[0]) || $past(wr_ien));

endmodule

// File: tb/test_match_timer.sv
`timescale 1ns/1ps
module test_match_timer;
  localparam int CW = 32;
  localparam int NC = 4;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_CNT  = 6'h10;
  localparam logic [AW-1:0] A_STAT = 6'h14;
  localparam logic [AW-1:0] A_WDOG = 6'h18;
  localparam logic [AW-1:0] A_IEN  = 6'h1C;

  logic          clk = 1'b0;
  logic          rst_n, tick_en, bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [CW-1:0] bus_wdata, bus_rdata;
  logic [NC-1:0] irq;
  logic          wdog_rst_req;

  int n_chk = 0, n_fail = 0, pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  match_timer i_match_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .wdog_rst_req(wdog_rst_req)
  );

  always @(negedge clk) if (rst_n && wdog_rst_req) pulses++;

  function automatic logic [AW-1:0] a_cmp(input int c);
    return AW'(c * 4);
  endfunction
  function automatic logic [CW-1:0] after_ticks(input logic [CW-1:0] base, input int n);
    return base + CW'(n);
  endfunction
  function automatic logic gate(input logic [NC-1:0] st, input logic [NC-1:0] en, input int c);
    return st[c] && en[c];
  endfunction

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [CW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [CW-1:0] v;
    logic [NC-1:0] en;
    int ch, d;
    logic [CW-1:0] base;
    void'($urandom(32'd1234));
    rst_n = 1'b0; tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int r = 0; r < 8; r++) begin
      rd_reg(AW'(r * 4), v);
      check("R1 reg", v, 32'h0);
    end
    check("R1 irq", CW'(irq), 32'h0);
    check("R1 rst_req", CW'(wdog_rst_req), 32'h0);

    // R4 compare registers read back
    for (int c = 0; c < NC; c++) begin
      wr_reg(a_cmp(c), 32'hA5A5_0000 + CW'(c * 32'h1111));
    end
    for (int c = 0; c < NC; c++) begin
      rd_reg(a_cmp(c), v);
      check("R4 cmp", v, 32'hA5A5_0000 + CW'(c * 32'h1111));
    end

    // R2 count, hold, wrap
    wr_reg(A_CNT, 32'd100);
    ticks(7);
    rd_reg(A_CNT, v); check("R2 count", v, after_ticks(32'd100, 7));
    repeat (3) @(negedge clk);
    rd_reg(A_CNT, v); check("R2 hold", v, 32'd107);
    wr_reg(A_CNT, 32'hFFFF_FFFE);
    ticks(3);
    rd_reg(A_CNT, v); check("R2 wrap", v, 32'h1);

    // R3 load during a tick
    @(negedge clk);
    tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CNT; bus_wdata = 32'h1234;
    @(negedge clk);
    tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd_reg(A_CNT, v); check("R3 load wins", v, 32'h1234);

    // R5 loading the counter onto a target does not set status
    wr_reg(A_STAT, 32'hF);
    wr_reg(a_cmp(2), 32'h5000);
    wr_reg(A_CNT, 32'h5000);
    rd_reg(A_STAT, v); check("R5 load no set", v & 32'h4, 32'h0);

    // R5/R7 random targets
    for (int it = 0; it < 24; it++) begin
      ch = int'($urandom % NC);
      base = $urandom;
      d = 1 + int'($urandom % 40);
      en = NC'($urandom);
      wr_reg(A_IEN, CW'(en));
      wr_reg(a_cmp(ch), after_ticks(base, d));
      wr_reg(A_CNT, base);
      wr_reg(A_STAT, 32'hF);
      ticks(d - 1);
      rd_reg(A_STAT, v); check("R5 early", CW'(v[ch]), 32'h0);
      ticks(1);
      rd_reg(A_STAT, v); check("R5 on target", CW'(v[ch]), 32'h1);
      rd_reg(A_CNT, v); check("R5 count", v, after_ticks(base, d));
      check("R7 irq", CW'(irq[ch]), CW'(gate(NC'(1 << ch), en, ch)));
      wr_reg(A_STAT, CW'(1 << ch));
      rd_reg(A_STAT, v); check("R6 cleared", CW'(v[ch]), 32'h0);
    end

    // Keep other targets out of the way
    wr_reg(a_cmp(1), 32'h7000_0000);
    wr_reg(a_cmp(2), 32'h7100_0000);
    wr_reg(a_cmp(3), 32'h7200_0000);
    wr_reg(A_IEN, 32'h0);

    // R6 set outranks clear, write-0 keeps
    wr_reg(a_cmp(0), 32'h300);
    wr_reg(A_CNT, 32'h2FF);
    wr_reg(A_STAT, 32'hF);
    ticks(1);
    wr_reg(A_CNT, 32'h2FF);
    @(negedge clk);
    tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h1;
    @(negedge clk);
    tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd_reg(A_STAT, v); check("R6 set wins", v & 32'h1, 32'h1);
    wr_reg(A_STAT, 32'h0);
    rd_reg(A_STAT, v); check("R6 write0 keeps", v & 32'h1, 32'h1);
    wr_reg(A_STAT, 32'h1);
    rd_reg(A_STAT, v); check("R6 write1 clears", v & 32'h1, 32'h0);

    // R7 enable gating
    wr_reg(a_cmp(1), 32'h40);
    wr_reg(A_CNT, 32'h3F);
    wr_reg(A_STAT, 32'hF);
    ticks(1);
    check("R7 masked", CW'(irq), 32'h0);
    wr_reg(A_IEN, 32'h2);
    @(negedge clk); check("R7 enabled", CW'(irq), 32'h2);
    wr_reg(A_IEN, 32'hD);
    @(negedge clk); check("R7 disabled", CW'(irq), 32'h0);
    wr_reg(A_IEN, 32'h0);

    // R11 passed target fires only after wrap
    wr_reg(A_STAT, 32'hF);
    wr_reg(a_cmp(1), 32'h10);
    wr_reg(A_CNT, 32'h20);
    ticks(5);
    rd_reg(A_STAT, v); check("R11 passed", v & 32'h2, 32'h0);
    wr_reg(A_CNT, 32'hFFFF_FFFE);
    ticks(2);
    rd_reg(A_CNT, v); check("R11 wrapped", v, 32'h0);
    rd_reg(A_STAT, v); check("R11 not yet", v & 32'h2, 32'h0);
    ticks(16);
    rd_reg(A_STAT, v); check("R11 fires", v & 32'h2, 32'h2);

    // R9 disarmed: status sets, no request
    wr_reg(A_STAT, 32'hF);
    wr_reg(a_cmp(3), 32'h800);
    wr_reg(A_CNT, 32'h7FF);
    ticks(1);
    repeat (2) @(negedge clk);
    check("R9 no req disarmed", CW'(pulses), 32'h0);
    rd_reg(A_STAT, v); check("R9 stat3", v & 32'h8, 32'h8);

    // R8 arm flag
    wr_reg(A_WDOG, 32'h2);
    rd_reg(A_WDOG, v); check("R8 bit0 only", v, 32'h0);
    wr_reg(A_WDOG, 32'h1);
    rd_reg(A_WDOG, v); check("R8 armed", v, 32'h1);
    wr_reg(A_WDOG, 32'h0);
    rd_reg(A_WDOG, v); check("R8 sticky", v, 32'h1);

    // R9 armed: one-cycle request with status
    wr_reg(A_STAT, 32'hF);
    wr_reg(A_CNT, 32'h7FF);
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    check("R9 req high", CW'(wdog_rst_req), 32'h1);
    @(negedge clk);
    check("R9 req low", CW'(wdog_rst_req), 32'h0);
    repeat (2) @(negedge clk);
    check("R9 one pulse", CW'(pulses), 32'h1);

    // R10 unmapped addresses
    wr_reg(A_IEN, 32'h5);
    wr_reg(A_CNT, 32'h777);
    wr_reg(6'h20, 32'hFFFF_FFFF);
    wr_reg(6'h3C, 32'hFFFF_FFFF);
    wr_reg(6'h11, 32'h1);
    wr_reg(6'h1D, 32'hF);
    rd_reg(6'h20, v); check("R10 read high", v, 32'h0);
    rd_reg(6'h12, v); check("R10 read unaligned", v, 32'h0);
    rd_reg(A_CNT, v); check("R10 count kept", v, 32'h777);
    rd_reg(A_IEN, v); check("R10 ien kept", v, 32'h5);
    rd_reg(a_cmp(0), v); check("R10 cmp0 kept", v, 32'h300);

    done = 1'b1;
    summary();
  end

endmodule